// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus N Divider

This block divides an input clock by a programmable 17-bit ratio N. It does so the way a dual-modulus synthesizer divider does: a prescaler that can divide by 8 or by 9 is steered by two counters. The low three bits of N set a swallow count A. The upper fourteen bits set a main count B. In each output period the prescaler runs B times. It divides by 9 on the first A of those runs and by 8 on the others, so one period lasts 8·B + A input cycles. The prescaler is modelled as ordinary synchronous logic.

Because A can never be larger than B, and B has a floor, some small ratios cannot be built. The block checks the programmed ratio all the time and raises a flag when it is not allowed. While the flag is up, the divider output stays quiet. The enable input is driven by power-down: taking it low stops the divider at once and clears its counters. A ratio written while the divider runs is picked up only when the current period ends, so no period is ever cut short.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While rst_n is low, div_pulse is 0 and the divider is stopped. After reset is released with enable high and a legal ratio, the first pulse comes N cycles after the first clock edge with rst_n high.
- R2: The swallow count is A = n_value[2:0] and the main count is B = n_value[16:3]. A ratio is legal exactly when B ≥ 3 and A ≤ B. This gives 24–27, 32–36, 40–45 and 48–54 below 56, and nothing below 24. n_illegal is high exactly when n_value is not legal, and it follows n_value in the same cycle.
- R3: Every ratio from 56 to 131071 is legal and divides by exactly that ratio.
- R4: With a legal ratio N held and enable high, div_pulse goes high exactly once every N input cycles. The first pulse comes N cycles after the edge that starts the divider.
- R5: div_pulse is high for exactly one input cycle per period.
- R6: While enable is low, div_pulse stays 0 and the counters are cleared. When enable returns, a fresh period starts, and its first pulse comes N cycles later.
- R7: A ratio changed in the middle of a period does not alter that period. The new ratio sets the length of the following period.
- R8: While n_value is illegal, div_pulse is held at 0. If the ratio is still illegal at a period boundary, the divider halts. It restarts with a full period as soon as a legal ratio is present.
- R9: Within a period, the remaining swallow count never exceeds the remaining main count. Both extreme swallow counts, A = 0 and A = 7, give a period of exactly 8·B + A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low means power-down |
| n_value | input | 17 | Programmed divide ratio N |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| n_illegal | output | 1 | High while n_value is not an allowed ratio |

## Verification
The hardest case to reach is a ratio change that lands inside a period already under way. This matters most when the new ratio is illegal and must then halt the divider at the boundary rather than at once. The bench first locks onto a pulse so that it knows exactly where the period stands. It then changes n_value a known number of cycles into the period. Next it measures the distance to the next pulse, and to the one after that. Finally it restores a legal ratio and times the restart.

// File: rtl/psd_pkg.sv
package psd_pkg;
   // run state of the swallow controller
   typedef enum logic {
      PSD_IDLE = 1'b0,
      PSD_RUN  = 1'b1
   } psd_state_e;

   localparam int PSD_SWALLOW_W = 3;   // bits of N feeding the A counter
   localparam int PSD_MAIN_W    = 14;  // bits of N feeding the B counter
   localparam int PSD_MAIN_MIN  = 3;   // smallest usable B
endpackage

// File: rtl/psd_legality.sv
module psd_legality #(
   parameter int A_W   = 3,
   parameter int B_W   = 14,
   parameter int MIN_B = 3
) (
   input  logic [A_W+B_W-1:0] n_value,
   output logic               legal
);
   logic [A_W-1:0] a_part;
   logic [B_W-1:0] b_part;

   assign a_part = n_value[A_W-1:0];
   assign b_part = n_value[A_W+B_W-1:A_W];

   // a ratio can be built only if B reaches its floor and A fits inside B
   always_comb begin
      legal = (b_part >= B_W'(MIN_B)) && (B_W'(a_part) <= b_part);
   end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
   parameter int A_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic restart,
   input  logic hi_mod,
   output logic tc
);
   localparam int              PC_W    = A_W + 1;
   localparam logic [PC_W-1:0] LO_LAST = PC_W'((1 << A_W) - 1);
   localparam logic [PC_W-1:0] HI_LAST = PC_W'(1 << A_W);

   logic [PC_W-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (clr) begin
         pc <= '0;
      end else if (restart) begin
         pc <= hi_mod ? HI_LAST : LO_LAST;
      end else if (pc != '0) begin
         pc <= pc - PC_W'(1);
      end
   end

   assign tc = (pc == '0);
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
   import psd_pkg::*;
#(
   parameter int A_W = 3,
   parameter int B_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               legal,
   input  logic [A_W+B_W-1:0] n_value,
   input  logic               tc,
   output logic               restart,
   output logic               hi_mod,
   output logic               pre_clr,
   output logic               period_end,
   output logic               running,
   output logic [A_W-1:0]     a_left,
   output logic [B_W-1:0]     b_left
);
   psd_state_e     state;
   logic [A_W-1:0] a_new;
   logic [B_W-1:0] b_new;
   logic           last_run;
   logic           load_now;
   logic           step;
   logic           halt;

   assign a_new    = n_value[A_W-1:0];
   assign b_new    = n_value[A_W+B_W-1:A_W];
   assign running  = (state == PSD_RUN);
   assign last_run = running && tc && (b_left == B_W'(1));

   always_comb begin
      load_now   = enable && legal && (!running || last_run);
      step       = enable && running && tc && !last_run;
      halt       = !enable || (last_run && !legal);
      restart    = load_now || step;
      hi_mod     = load_now ? (a_new != '0) : (a_left > A_W'(1));
      pre_clr    = halt;
      period_end = last_run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PSD_IDLE;
         a_left <= '0;
         b_left <= '0;
      end else if (halt) begin
         state  <= PSD_IDLE;
         a_left <= '0;
         b_left <= '0;
      end else if (load_now) begin
         state  <= PSD_RUN;
         a_left <= a_new;
         b_left <= b_new;
      end else if (step) begin
         b_left <= b_left - B_W'(1);
         if (a_left != '0) begin
            a_left <= a_left - A_W'(1);
         end
      end
   end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
   import psd_pkg::*;
#(
   parameter int A_W       = PSD_SWALLOW_W,
   parameter int B_W       = PSD_MAIN_W,
   parameter int MIN_B     = PSD_MAIN_MIN,
   parameter bit PULSE_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [A_W+B_W-1:0] n_value,
   output logic               div_pulse,
   output logic               n_illegal
);
   localparam int N_W = A_W + B_W;

   if (A_W < 1)      begin : g_bad_a  $error("A_W must be at least 1");  end
   if (B_W <= A_W)   begin : g_bad_b  $error("B_W must exceed A_W");     end
   if (MIN_B < 2)    begin : g_bad_mb $error("MIN_B must be at least 2"); end

   logic           legal;
   logic           tc;
   logic           restart;
   logic           hi_mod;
   logic           pre_clr;
   logic           period_end;
   logic           running;
   logic [A_W-1:0] a_left;
   logic [B_W-1:0] b_left;

   psd_legality #(.A_W(A_W), .B_W(B_W), .MIN_B(MIN_B)) u_legal (
      .n_value (n_value),
      .legal   (legal)
   );

   psd_prescaler #(.A_W(A_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pre_clr),
      .restart (restart),
      .hi_mod  (hi_mod),
      .tc      (tc)
   );

   psd_swallow_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .legal      (legal),
      .n_value    (n_value[N_W-1:0]),
      .tc         (tc),
      .restart    (restart),
      .hi_mod     (hi_mod),
      .pre_clr    (pre_clr),
      .period_end (period_end),
      .running    (running),
      .a_left     (a_left),
      .b_left     (b_left)
   );

   assign n_illegal = !legal;

   if (PULSE_REG) begin : g_out_reg
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= period_end;
      end
      assign div_pulse = pulse_q && enable && legal;
   end else begin : g_out_comb
      assign div_pulse = period_end && enable && legal;
   end
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
   parameter int A_W   = 3,
   parameter int B_W   = 14,
   parameter int MIN_B = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           enable,
   input logic           n_illegal,
   input logic           div_pulse,
   input logic           running,
   input logic [A_W-1:0] a_left,
   input logic [B_W-1:0] b_left
);
   localparam int GAP_W = A_W + B_W + 1;
   localparam int MIN_N = MIN_B << A_W;

   logic [GAP_W-1:0] gap;
   logic             seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (!enable) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (div_pulse) begin
         gap  <= GAP_W'(1);
         seen <= 1'b1;
      end else if (gap != '1) begin
         gap  <= gap + GAP_W'(1);
      end
   end

   always @(negedge clk) begin
      if (!rst_n) p_reset_quiet_r1: assert (!div_pulse);
   end

   p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !div_pulse);

   p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      n_illegal |-> !div_pulse);

   p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   p_swallow_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (B_W'(a_left) <= b_left));

   p_period_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (div_pulse && seen) |-> (gap >= GAP_W'(MIN_N)));
endmodule

bind pulse_swallow_divider psd_checker #(.A_W(A_W), .B_W(B_W), .MIN_B(MIN_B)) u_psd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .n_illegal (n_illegal),
   .div_pulse (div_pulse),
   .running   (running),
   .a_left    (a_left),
   .b_left    (b_left)
);

// File: tb/tb_pulse_swallow_divider.sv
`timescale 1ns/1ps
module tb_pulse_swallow_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [16:0] n_value = '0;
   wire         div_pulse;
   wire         n_illegal;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   pulse_swallow_divider dut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .n_value(n_value), .div_pulse(div_pulse), .n_illegal(n_illegal)
   );

   localparam int NV = 14;
   // ratio under test and whether it is an allowed ratio (R2 rule)
   localparam int TV_N  [NV] = '{23, 24, 27, 28, 31, 32, 36, 37, 45, 54, 55, 56, 63, 4099};
   localparam bit TV_OK [NV] = '{0,  1,  1,  0,  0,  1,  1,  0,  1,  1,  0,  1,  1,  1};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // count sampled cycles until a pulse is seen (or limit reached)
   task automatic wait_pulse(input int limit, output int cnt);
      cnt = 0;
      do begin
         tick();
         cnt++;
      end while (!div_pulse && cnt < limit);
   endtask

   task automatic count_pulses(input int cycles, output int pulses);
      pulses = 0;
      for (int k = 0; k < cycles; k++) begin
         tick();
         if (div_pulse) pulses++;
      end
   endtask

   initial begin
      int c;
      int p;
      string rq;
      // R1: reset state
      enable  = 1'b1;
      n_value = 17'd24;
      repeat (4) tick();
      chk(div_pulse == 1'b0, "R1", div_pulse, 0);
      rst_n = 1'b1;
      wait_pulse(60, c);
      chk(c == 24, "R1", c, 24);

      // table walk: legality flag, first period, width, second period
      for (int i = 0; i < NV; i++) begin
         enable  = 1'b0;
         n_value = 17'(TV_N[i]);
         tick();
         chk(n_illegal == !TV_OK[i], "R2", n_illegal, !TV_OK[i]);
         enable = 1'b1;
         if (TV_OK[i]) begin
            rq = (TV_N[i] >= 56) ? "R3" : ((TV_N[i] % 8 == 7 || TV_N[i] % 8 == 0) ? "R9" : "R4");
            wait_pulse(TV_N[i] + 4, c);
            chk(c == TV_N[i], rq, c, TV_N[i]);
            tick();
            chk(div_pulse == 1'b0, "R5", div_pulse, 0);
            wait_pulse(TV_N[i] + 4, c);
            chk(c == TV_N[i] - 1, "R4", c + 1, TV_N[i]);
         end else begin
            count_pulses(130, p);
            chk(p == 0, "R8", p, 0);
         end
      end

      // R6: power-down mid-period, then fresh restart
      enable  = 1'b0;
      n_value = 17'd40;
      tick();
      enable = 1'b1;
      repeat (10) tick();
      enable = 1'b0;
      count_pulses(60, p);
      chk(p == 0, "R6", p, 0);
      enable = 1'b1;
      wait_pulse(80, c);
      chk(c == 40, "R6", c, 40);

      // R7: change ratio 5 cycles into a period
      enable  = 1'b0;
      n_value = 17'd24;
      tick();
      enable = 1'b1;
      wait_pulse(40, c);
      chk(c == 24, "R7", c, 24);
      repeat (5) tick();
      n_value = 17'd50;
      wait_pulse(40, c);
      chk(c == 19, "R7", c + 5, 24);
      wait_pulse(80, c);
      chk(c == 50, "R7", c, 50);

      // R8: illegal ratio at boundary halts; legal ratio restarts
      n_value = 17'd28;
      tick();
      chk(n_illegal == 1'b1, "R2", n_illegal, 1);
      count_pulses(120, p);
      chk(p == 0, "R8", p, 0);
      n_value = 17'd40;
      wait_pulse(80, c);
      chk(c == 40, "R8", c, 40);

      // R8: illegal only briefly inside a period masks nothing at its end
      repeat (10) tick();
      n_value = 17'd31;
      repeat (5) tick();
      n_value = 17'd40;
      wait_pulse(80, c);
      chk(c == 25, "R8", c + 15, 40);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule